// File: doc/BRIEF.md
# Word Granularity Data Reorder Unit

This unit reorders the bits of a 128-bit cipher data block, which is carried as four 32-bit bus words, so that software can hand data over in its natural element size and get results back the same way. A 2-bit selector picks the element granularity inside each 32-bit word: whole word (no change), half-word, byte or single bit. Each word is handled separately, and no bit ever moves from one word to another.

The unit sits on two paths at once. The input path takes the block assembled from bus writes and turns it into the value loaded into the core register. The output path takes the core result and turns it back into bus words. One selector drives both paths, so one reorder on the way in and the same reorder on the way out cancel each other. The logic only moves bits and never changes their values. A parameter adds a synchronous output register on both paths, and that register is present by default.

Top module: `data_swap_unit`

## Requirements
- R1: A block is 128 bits wide and holds four independent 32-bit words. Word k occupies bits [32k+31:32k]. No bit of a word ever appears in a different word.
- R2: With selector 2'b00 (32-bit elements), every word passes through unchanged.
- R3: With selector 2'b01 (16-bit elements), the upper and lower half-words of each word trade places: output bits [15:0] take input bits [31:16], and output bits [31:16] take input bits [15:0].
- R4: With selector 2'b10 (8-bit elements), the byte order inside each word is reversed: output byte j takes input byte 3-j.
- R5: With selector 2'b11 (1-bit elements), all 32 bits of each word are reversed: output bit i takes input bit 31-i.
- R6: The same selector value drives the input path and the output path. When the input path's result is passed through the output path, the original block comes back for every selector value.
- R7: With the output register enabled (the default), each path's result appears one clock after its inputs. Synchronous active-high reset clears both registered outputs to zero.
- R8: Bit values are never altered: each output word contains the same number of ones as the input word it came from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_sel | input | 2 | Element granularity: 00 word, 01 half-word, 10 byte, 11 bit |
| bus_blk_i | input | 128 | Block assembled from bus words, input path |
| core_blk_o | output | 128 | Reordered block for the core register |
| core_res_i | input | 128 | Core result block, output path |
| bus_res_o | output | 128 | Reordered result for the bus words |

## Verification
With the default register, both outputs are due exactly one rising edge after the inputs and the selector are set. The bench therefore drives all inputs on the falling edge and samples one time unit after the next rising edge. A latency check samples just before that edge and expects the previous value still to be present. The round trip feeds the registered input-path result into the output path on the next falling edge and compares the result one edge later. The reset check samples one edge after reset is asserted.

// File: rtl/swap_pkg.sv
package swap_pkg;
  typedef enum logic [1:0] {
    GRAN_WORD = 2'b00,
    GRAN_HALF = 2'b01,
    GRAN_BYTE = 2'b10,
    GRAN_BIT  = 2'b11
  } swap_gran_e;
endpackage

// File: rtl/swap_word.sv
module swap_word
  import swap_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  swap_gran_e          gran,
  input  logic [WORD_W-1:0]   din,
  output logic [WORD_W-1:0]   dout
);
  localparam int HALF_W = WORD_W / 2;
  localparam int BYTES  = WORD_W / 8;

  logic [WORD_W-1:0] half_x;
  logic [WORD_W-1:0] byte_r;
  logic [WORD_W-1:0] bit_r;

  assign half_x = {din[HALF_W-1:0], din[WORD_W-1:HALF_W]};

  genvar gb;
  generate
    for (gb = 0; gb < BYTES; gb++) begin : g_byte
      assign byte_r[8*gb +: 8] = din[8*(BYTES-1-gb) +: 8];
    end
    for (gb = 0; gb < WORD_W; gb++) begin : g_bit
      assign bit_r[gb] = din[WORD_W-1-gb];
    end
  endgenerate

  always_comb begin
    unique case (gran)
      GRAN_HALF: dout = half_x;
      GRAN_BYTE: dout = byte_r;
      GRAN_BIT:  dout = bit_r;
      default:   dout = din;
    endcase
  end
endmodule

// File: rtl/swap_stage.sv
module swap_stage
  import swap_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int BLK_W   = 128,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  swap_gran_e       gran,
  input  logic [BLK_W-1:0] din,
  output logic [BLK_W-1:0] dout
);
  localparam int NWORDS = BLK_W / WORD_W;

  logic [BLK_W-1:0] swapped;

  genvar gw;
  generate
    for (gw = 0; gw < NWORDS; gw++) begin : g_word
      swap_word #(.WORD_W(WORD_W)) u_word (
        .gran (gran),
        .din  (din[WORD_W*gw +: WORD_W]),
        .dout (swapped[WORD_W*gw +: WORD_W])
      );
    end

    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) dout <= '0;
        else     dout <= swapped;
      end
    end else begin : g_comb
      assign dout = swapped;
    end
  endgenerate
endmodule

// File: rtl/data_swap_unit.sv
module data_swap_unit
  import swap_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int BLK_W   = 128,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       swap_sel,
  input  logic [BLK_W-1:0] bus_blk_i,
  output logic [BLK_W-1:0] core_blk_o,
  input  logic [BLK_W-1:0] core_res_i,
  output logic [BLK_W-1:0] bus_res_o
);
  localparam int NWORDS = BLK_W / WORD_W;
  localparam int HALF_W = WORD_W / 2;

  swap_gran_e gran;
  assign gran = swap_gran_e'(swap_sel);   // R6: one selector for both paths

  swap_stage #(.WORD_W(WORD_W), .BLK_W(BLK_W), .OUT_REG(OUT_REG)) u_in_path (
    .clk  (clk),
    .rst  (rst),
    .gran (gran),
    .din  (bus_blk_i),
    .dout (core_blk_o)
  );

  swap_stage #(.WORD_W(WORD_W), .BLK_W(BLK_W), .OUT_REG(OUT_REG)) u_out_path (
    .clk  (clk),
    .rst  (rst),
    .gran (gran),
    .din  (core_res_i),
    .dout (bus_res_o)
  );

  generate
    if (OUT_REG) begin : g_chk
      AST_WORD_PASS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(swap_sel) == 2'b00) |-> core_blk_o == $past(bus_blk_i)); // R2
      AST_HALF_TRADE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(swap_sel) == 2'b01) |->
          core_blk_o[HALF_W-1:0] == $past(bus_blk_i[WORD_W-1:HALF_W])); // R3
      AST_BYTE_REV: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(swap_sel) == 2'b10) |->
          bus_res_o[7:0] == $past(core_res_i[WORD_W-1:WORD_W-8])); // R4
      AST_BIT_REV: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(swap_sel) == 2'b11) |->
          (core_blk_o[0] == $past(bus_blk_i[WORD_W-1]) &&
           bus_res_o[WORD_W-1] == $past(core_res_i[0]))); // R5
      for (genvar k = 0; k < NWORDS; k++) begin : g_ones
        AST_ONES_KEPT: assert property (@(posedge clk) disable iff (rst)
          !$past(rst) |->
            ($countones(core_blk_o[WORD_W*k +: WORD_W]) ==
               $countones($past(bus_blk_i[WORD_W*k +: WORD_W])) &&
             $countones(bus_res_o[WORD_W*k +: WORD_W]) ==
               $countones($past(core_res_i[WORD_W*k +: WORD_W])))); // R8
      end
    end
  endgenerate
endmodule

// File: tb/tb_data_swap_unit.sv
module tb_data_swap_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   swap_sel = 2'b00;
  logic [127:0] bus_blk_i = '0;
  logic [127:0] core_res_i = '0;
  logic [127:0] core_blk_o;
  logic [127:0] bus_res_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  data_swap_unit dut (
    .clk(clk), .rst(rst), .swap_sel(swap_sel),
    .bus_blk_i(bus_blk_i), .core_blk_o(core_blk_o),
    .core_res_i(core_res_i), .bus_res_o(bus_res_o)
  );

  // Reference: source bit index for each output bit, from the requirements.
  function automatic logic [127:0] ref_swap(input logic [1:0] s, input logic [127:0] d);
    logic [127:0] r;
    for (int w = 0; w < 4; w++) begin
      for (int j = 0; j < 32; j++) begin
        int src;
        case (s)
          2'b00:   src = j;
          2'b01:   src = (j + 16) % 32;
          2'b10:   src = 8 * (3 - j / 8) + (j % 8);
          default: src = 31 - j;
        endcase
        r[32*w + j] = d[32*w + src];
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] s, input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    swap_sel   = s;
    bus_blk_i  = a;
    core_res_i = b;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    bus_blk_i = {4{32'hDEAD_BEEF}};
    core_res_i = {4{32'h1234_5678}};
    @(posedge clk); #1;
    check("R7 reset core_blk_o", core_blk_o, '0);
    check("R7 reset bus_res_o", bus_res_o, '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_gran(input logic [1:0] s, input string req);
    logic [127:0] pats [3];
    pats[0] = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    pats[1] = 128'h8000_0001_00FF_FF00_F0F0_0F0F_1357_9BDF;
    pats[2] = 128'hA5A5_5A5A_C3C3_3C3C_0000_FFFF_1111_8888;
    for (int p = 0; p < 3; p++) begin
      apply(s, pats[p], ~pats[(p + 1) % 3]);
      check({req, " in-path"}, core_blk_o, ref_swap(s, pats[p]));
      check({req, " out-path"}, bus_res_o, ref_swap(s, ~pats[(p + 1) % 3]));
    end
  endtask

  // R1: a single set bit stays inside its own word for every setting.
  task automatic t_isolation();
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 4; w++) begin
        logic [127:0] one;
        logic [127:0] mask;
        one  = 128'(1) << (32 * w + 5);
        mask = 128'(32'hFFFF_FFFF) << (32 * w);
        apply(2'(s), one, one);
        check("R1 word isolation", core_blk_o & ~mask, '0);
        check("R1 bit kept", 128'($countones(core_blk_o)), 128'(1));
      end
    end
  endtask

  task automatic t_roundtrip();
    for (int s = 0; s < 4; s++) begin
      logic [127:0] orig;
      orig = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0 ^ (128'(s) * 128'h1357_1357);
      apply(2'(s), orig, '0);
      apply(2'(s), '0, core_blk_o);
      check("R6 round trip", bus_res_o, orig);
    end
  endtask

  task automatic t_latency();
    apply(2'b11, 128'h1, 128'h2);
    @(negedge clk);
    bus_blk_i = 128'h4;
    #8;
    check("R7 hold before edge", core_blk_o, ref_swap(2'b11, 128'h1));
    @(posedge clk); #1;
    check("R7 one clock later", core_blk_o, ref_swap(2'b11, 128'h4));
  endtask

  task automatic t_ones();
    logic [127:0] d;
    d = 128'hFFFF_0001_7000_000E_8421_1248_0000_0000;
    for (int s = 0; s < 4; s++) begin
      apply(2'(s), d, d);
      for (int w = 0; w < 4; w++)
        check("R8 ones per word", 128'($countones(core_blk_o[32*w +: 32])),
              128'($countones(d[32*w +: 32])));
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        t_reset();
        t_gran(2'b00, "R2 word");
        t_gran(2'b01, "R3 half");
        t_gran(2'b10, "R4 byte");
        t_gran(2'b11, "R5 bit");
        t_isolation();
        t_roundtrip();
        t_latency();
        t_ones();
        t_reset();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_checks++;
          n_fails++;
          $display("FAIL watchdog act=timeout exp=finish");
        end
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule